// File: doc/BRIEF.md
# Header Arbitration Sequencer

This block decides when a node may put a header byte on a single-wire, open-drain serial bus, and what it does when it has to share the bus. On a start request it waits for a programmed idle gap (never shorter than 20 bit times) when asked to. It then sends the header byte with a start and stop bit and reads every data bit back from the wire. The wire is a wired AND: a low level is dominant. A node that sent a 1 and reads a 0 has lost. It releases the wire at once and the winner's header carries on intact.

A losing node does not drop out. It keeps collecting the winning header and the response bytes that follow, and hands each byte to the next stage. After that frame it waits for the idle gap again and retries, up to a programmed limit. When the limit is used up, it raises a one-cycle lost pulse, finishes receiving the current frame and stops. A gap between received bytes that runs past a programmed limit ends the frame with a timeout pulse.

The line coding of single bits lies outside this block. A one-cycle `bit_tick` marks each bit's sampling point. At that tick the block samples `rx_in` and updates `tx_out` for the next bit. The response length in bytes comes from the stage that decodes the frame.

Top module: `hdr_arbiter`

## Requirements
- R1: After reset `tx_out` is 1 (wire released), `busy` is 0, and `hdr_done`, `arb_lost`, `ibs_timeout` and `rx_vld` are 0.
- R2: With `wait_idle`=0, the start bit (0) is driven from the first `bit_tick` after `start`. Each following tick drives the next bit: the 8 bits of `hdr_id`, bit 0 first, then a stop bit (1). At the tick that samples the stop bit, `hdr_done` pulses for one cycle.
- R3: With `wait_idle`=1, the start bit is driven at bit tick number N+1 counted from the moment the wire went high, where N = max(`ifs_bits`, 20).
- R4: Any low level on `rx_in`, even one between two ticks, resets the idle count to zero, so the gap of R3 is counted again from the next tick.
- R5: A loss occurs when a header data bit was sent as 1 and is sampled as 0. After a loss `tx_out` stays 1 until the frame ends. A node that wins the collision completes its header and pulses `hdr_done`.
- R6: After a loss, the block presents every byte of the frame on `rx_byte`: the header, then `rsp_bytes` response bytes. Each byte comes with a one-cycle `rx_vld` at the tick that samples its stop bit, data bit 0 first. A byte starts at the first tick that samples a 0 between bytes.
- R7: A loss while fewer than `max_retry` retries have been used gives no `arb_lost`. After the frame, the block waits for the idle gap of R3 and sends its header again.
- R8: A loss when `max_retry` retries have already been used pulses `arb_lost` at the loss tick. The block then receives the frame, makes no further attempt, and `busy` falls when the frame ends.
- R9: While it receives between bytes, `ibs_limit`+1 consecutive high ticks pulse `ibs_timeout` at the last of them, and the block goes idle.
- R10: With `wait_idle`=1, a start bit seen on the wire during the wait is received as a frame (as in R6) without counting as a loss. The block then waits for the gap and transmits.
- R11: `hdr_done`, `arb_lost` and `ibs_timeout` are never high together, and all status pulses occur only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe at each bit's sampling point |
| rx_in | input | 1 | Level read from the wire |
| start | input | 1 | Request one header attempt sequence |
| wait_idle | input | 1 | Check the idle gap before the first attempt |
| hdr_id | input | 8 | Header byte to send (wire low wins) |
| ifs_bits | input | CW | Required idle gap in bit times, floor 20 |
| ibs_limit | input | CW | Longest allowed gap between received bytes |
| rsp_bytes | input | CW | Response bytes that follow a received header |
| max_retry | input | RW | Retries allowed after losses |
| tx_out | output | 1 | Drive to the wire, 0 pulls low, 1 releases |
| busy | output | 1 | Sequence in progress |
| hdr_done | output | 1 | Pulse: own header sent without loss |
| arb_lost | output | 1 | Pulse: loss with retries used up |
| ibs_timeout | output | 1 | Pulse: gap between bytes too long |
| rx_vld | output | 1 | Pulse: `rx_byte` holds a received byte |
| rx_byte | output | 8 | Last received byte |

## Verification
The in-line assertions check, on every cycle, the rules that hold at any time. A low wire clears the idle count. The wait does not end while the count is short of the gap. The wire stays released whenever the block is receiving or idle. The status pulses are exclusive and follow a tick. The directed scenarios show what depends on a whole sequence: the exact tick on which the start bit goes out for several gaps, the clamp at 20 and a restart caused by a glitch. They also show the bit order on the wire, the winner and loser of a collision, the received byte stream, one retry against an exhausted limit, the exact tick of a timeout, and a frame caught during the wait.

// File: rtl/hdr_arbiter.sv
`timescale 1ns/1ps
module hdr_arbiter #(
  parameter int CW = 8,
  parameter int RW = 4,
  parameter int IFS_MIN = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          rx_in,
  input  logic          start,
  input  logic          wait_idle,
  input  logic [7:0]    hdr_id,
  input  logic [CW-1:0] ifs_bits,
  input  logic [CW-1:0] ibs_limit,
  input  logic [CW-1:0] rsp_bytes,
  input  logic [RW-1:0] max_retry,
  output logic          tx_out,
  output logic          busy,
  output logic          hdr_done,
  output logic          arb_lost,
  output logic          ibs_timeout,
  output logic          rx_vld,
  output logic [7:0]    rx_byte
);
  localparam logic [CW-1:0] IFS_FLOOR = CW'(IFS_MIN);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_TX, S_RX, S_IBS} st_t;
  st_t st;

  logic [3:0]    bitn;
  logic [7:0]    hid, sreg;
  logic [CW-1:0] icnt, bcnt, nb, eff;
  logic [RW-1:0] rt;
  logic          wq, fin, dbit, lose, gap_ok;

  assign eff    = (ifs_bits < IFS_FLOOR) ? IFS_FLOOR : ifs_bits;
  assign gap_ok = !wq || (icnt >= eff);
  assign dbit   = (bitn != 4'd0) && (bitn < 4'd9);
  assign lose   = dbit && hid[3'(bitn - 4'd1)] && !rx_in;
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    icnt <= '0;
    else if (!rx_in)               icnt <= '0;
    else if (bit_tick && icnt != '1) icnt <= icnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tx_out <= 1'b1; bitn <= '0; hid <= '0; sreg <= '0;
      bcnt <= '0; nb <= '0; rt <= '0; wq <= 1'b0; fin <= 1'b0;
      hdr_done <= 1'b0; arb_lost <= 1'b0; ibs_timeout <= 1'b0;
      rx_vld <= 1'b0; rx_byte <= '0;
    end else begin
      hdr_done <= 1'b0; arb_lost <= 1'b0; ibs_timeout <= 1'b0; rx_vld <= 1'b0;
      if (bit_tick && dbit && (st == S_TX || st == S_RX)) sreg <= {rx_in, sreg[7:1]};
      case (st)
        S_IDLE: if (start) begin
          hid <= hdr_id; wq <= wait_idle; rt <= '0; fin <= 1'b0; st <= S_GAP;
        end
        S_GAP: if (bit_tick) begin
          if (wq && !rx_in) begin
            st <= S_RX; bitn <= 4'd1; nb <= '0;
          end else if (gap_ok) begin
            st <= S_TX; tx_out <= 1'b0; bitn <= '0; nb <= '0;
          end
        end
        S_TX: if (bit_tick) begin
          if (bitn == 4'd9) begin
            hdr_done <= 1'b1; st <= S_IDLE; tx_out <= 1'b1;
          end else if (lose) begin
            tx_out <= 1'b1; st <= S_RX; bitn <= bitn + 4'd1;
            if (rt == max_retry) begin arb_lost <= 1'b1; fin <= 1'b1; end
            else rt <= rt + 1'b1;
          end else begin
            bitn <= bitn + 4'd1;
            tx_out <= (bitn < 4'd8) ? hid[bitn[2:0]] : 1'b1;
          end
        end
        S_RX: if (bit_tick) begin
          if (bitn == 4'd9) begin
            rx_vld <= 1'b1; rx_byte <= sreg;
            if (nb == rsp_bytes) begin
              st <= fin ? S_IDLE : S_GAP; wq <= 1'b1;
            end else begin
              nb <= nb + 1'b1; st <= S_IBS; bcnt <= '0;
            end
          end else bitn <= bitn + 4'd1;
        end
        S_IBS: if (bit_tick) begin
          if (!rx_in) begin
            st <= S_RX; bitn <= 4'd1;
          end else if (bcnt == ibs_limit) begin
            ibs_timeout <= 1'b1; st <= S_IDLE;
          end else bcnt <= bcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> tx_out); // R1
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && bit_tick && wq && rx_in && icnt < eff) |=> (st == S_GAP)); // R3
  AST_LOW_RESTARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rx_in |=> (icnt == '0)); // R4
  AST_QUIET_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX || st == S_IBS) |-> tx_out); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_done, arb_lost, ibs_timeout})); // R11
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done || arb_lost || ibs_timeout || rx_vld) |-> $past(bit_tick)); // R11
endmodule

// File: tb/tb_hdr_arbiter.sv
`timescale 1ns/1ps
module tb_hdr_arbiter;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wait_idle = 1'b0, other = 1'b1;
  logic [7:0] hdr_id = 8'h00, ifs_bits = 8'd20, ibs_limit = 8'd8, rsp_bytes = 8'd0;
  logic [3:0] max_retry = 4'd0;
  logic [1:0] tc;
  logic bit_tick, rx_in, tx_out, busy, hdr_done, arb_lost, ibs_timeout, rx_vld;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, n_done = 0, n_lost = 0, n_to = 0, rxn = 0, txlow = 0;
  logic watch = 1'b0;
  logic [7:0] rxq [0:31];

  always #5 clk = ~clk;
  assign rx_in = tx_out & other;
  assign bit_tick = (tc == 2'd3);
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tc <= 2'd0; else tc <= tc + 2'd1;

  hdr_arbiter dut (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in),
    .start(start), .wait_idle(wait_idle), .hdr_id(hdr_id), .ifs_bits(ifs_bits),
    .ibs_limit(ibs_limit), .rsp_bytes(rsp_bytes), .max_retry(max_retry),
    .tx_out(tx_out), .busy(busy), .hdr_done(hdr_done), .arb_lost(arb_lost),
    .ibs_timeout(ibs_timeout), .rx_vld(rx_vld), .rx_byte(rx_byte));

  always @(posedge clk) begin
    if (hdr_done) n_done++;
    if (arb_lost) n_lost++;
    if (ibs_timeout) n_to++;
    if (rx_vld) begin rxq[rxn[4:0]] = rx_byte; rxn++; end
  end
  always @(negedge clk) if (watch && !tx_out) txlow++;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", r, act, exp); end
  endtask
  task automatic tick();
    do @(negedge clk); while (!bit_tick);
    @(posedge clk); #2;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic settle();
    @(posedge clk); #2;
  endtask
  task automatic go(input logic w);
    wait_idle = w; start = 1'b1; settle(); start = 1'b0;
  endtask
  task automatic glitch();
    other = 1'b0; settle(); other = 1'b1;
  endtask
  task automatic send_byte(input logic [7:0] b, input int watch_from);
    other = 1'b0; tick();
    for (int i = 0; i < 8; i++) begin
      other = b[i]; tick();
      if (i == watch_from) watch = 1'b1;
    end
    other = 1'b1; tick();
  endtask
  task automatic wait_tx(output int k);
    k = 0;
    while (tx_out && k < 80) begin tick(); k++; end
  endtask

  task automatic t_reset();
    chk(tx_out == 1'b1, "R1 tx released", int'(tx_out), 1);
    chk(busy == 1'b0, "R1 not busy", int'(busy), 0);
    chk({hdr_done, arb_lost, ibs_timeout, rx_vld} == 4'b0, "R1 no pulses",
        int'({hdr_done, arb_lost, ibs_timeout, rx_vld}), 0);
  endtask

  task automatic t_frame();
    int d0, bad;
    logic [7:0] h;
    h = 8'hA5; hdr_id = h; max_retry = 4'd0; d0 = n_done; bad = 0;
    tick(); go(1'b0); tick();
    chk(tx_out == 1'b0, "R2 start bit", int'(tx_out), 0);
    for (int i = 0; i < 8; i++) begin tick(); if (tx_out != h[i]) bad++; end
    chk(bad == 0, "R2 data bits lsb first", bad, 0);
    tick();
    chk(tx_out == 1'b1, "R2 stop bit", int'(tx_out), 1);
    tick(); settle();
    chk(n_done == d0 + 1, "R2 done pulse", n_done - d0, 1);
  endtask

  task automatic t_gap(input int ifs, input int g, input int exp, input string r);
    int k, d0;
    ifs_bits = 8'(ifs); hdr_id = 8'h55; max_retry = 4'd0; d0 = n_done;
    tick(); start = 1'b1; wait_idle = 1'b1; other = 1'b0; settle();
    start = 1'b0; settle(); other = 1'b1;
    k = 0;
    while (tx_out && k < 80) begin
      tick(); k++;
      if (g != 0 && k == g) glitch();
    end
    chk(k == exp, r, k, exp);
    ticks(10); settle();
    chk(n_done == d0 + 1, "R3 header completes after gap", n_done - d0, 1);
    ticks(2);
  endtask

  task automatic t_lose();
    int l0, r0;
    hdr_id = 8'h0F; max_retry = 4'd0; rsp_bytes = 8'd2; ibs_limit = 8'd8;
    l0 = n_lost; r0 = rxn; txlow = 0;
    tick(); go(1'b0); tick();
    send_byte(8'h03, 2); ticks(2);
    send_byte(8'h5A, -1); tick();
    send_byte(8'hC3, -1); settle(); watch = 1'b0;
    chk(n_lost == l0 + 1, "R8 lost pulse on exhausted retries", n_lost - l0, 1);
    chk(txlow == 0, "R5 wire released after loss", txlow, 0);
    chk(rxn == r0 + 3, "R6 byte count", rxn - r0, 3);
    chk(rxq[r0[4:0]] == 8'h03, "R6 header byte", int'(rxq[r0[4:0]]), 8'h03);
    chk(rxq[5'(r0 + 1)] == 8'h5A, "R6 response byte 1", int'(rxq[5'(r0 + 1)]), 8'h5A);
    chk(rxq[5'(r0 + 2)] == 8'hC3, "R6 response byte 2", int'(rxq[5'(r0 + 2)]), 8'hC3);
    chk(busy == 1'b0, "R8 no further attempt", int'(busy), 0);
    ticks(2);
    chk(tx_out == 1'b1 && busy == 1'b0, "R8 stays idle", int'(busy), 0);
  endtask

  task automatic t_retry();
    int l0, d0, k;
    hdr_id = 8'h0F; max_retry = 4'd1; rsp_bytes = 8'd1; ifs_bits = 8'd20;
    l0 = n_lost; d0 = n_done;
    tick(); go(1'b0); tick();
    send_byte(8'h03, -1); tick();
    send_byte(8'h44, -1);
    chk(n_lost == l0, "R7 no lost pulse on first loss", n_lost - l0, 0);
    wait_tx(k);
    chk(k == 20, "R7 retry after idle gap", k, 20);
    ticks(10); settle();
    chk(n_done == d0 + 1, "R7 retry wins", n_done - d0, 1);
    ticks(2);
  endtask

  task automatic t_win();
    int l0, d0;
    hdr_id = 8'h12; max_retry = 4'd0; l0 = n_lost; d0 = n_done;
    tick(); go(1'b0); tick();
    send_byte(8'hFE, -1);
    settle();
    chk(n_done == d0 + 1 && n_lost == l0, "R5 collision winner completes", n_done - d0, 1);
    ticks(2);
  endtask

  task automatic t_timeout();
    int t0;
    hdr_id = 8'h0F; max_retry = 4'd0; rsp_bytes = 8'd3; ibs_limit = 8'd3;
    tick(); go(1'b0); tick();
    send_byte(8'h03, -1); tick();
    send_byte(8'h5A, -1);
    t0 = n_to;
    ticks(3); settle();
    chk(n_to == t0 && busy, "R9 no early timeout", n_to - t0, 0);
    tick(); settle();
    chk(n_to == t0 + 1, "R9 timeout pulse", n_to - t0, 1);
    chk(busy == 1'b0, "R9 idle after timeout", int'(busy), 0);
    ibs_limit = 8'd8; ticks(2);
  endtask

  task automatic t_catch();
    int l0, r0, d0, k;
    hdr_id = 8'h0F; max_retry = 4'd0; rsp_bytes = 8'd0; ifs_bits = 8'd20;
    l0 = n_lost; r0 = rxn; d0 = n_done;
    tick(); go(1'b1); glitch(); tick();
    send_byte(8'h03, -1); settle();
    chk(rxn == r0 + 1 && rxq[r0[4:0]] == 8'h03, "R10 frame received during wait",
        int'(rxq[r0[4:0]]), 8'h03);
    chk(n_lost == l0, "R10 not counted as loss", n_lost - l0, 0);
    wait_tx(k);
    chk(k == 20, "R10 sends after gap", k, 20);
    ticks(10); settle();
    chk(n_done == d0 + 1, "R10 header sent", n_done - d0, 1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    rst_n = 1'b1;
    ticks(2);
    t_reset();
    t_frame();
    t_gap(25, 0, 26, "R3 start after 25 idle bits");
    t_gap(5, 0, 21, "R3 gap floor of 20");
    t_gap(20, 10, 31, "R4 glitch restarts idle count");
    t_lose();
    t_retry();
    t_win();
    t_timeout();
    t_catch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule